// File: doc/BRIEF.md
# CAN overload condition detector

This block sits beside the bit-level framing logic of a CAN controller and decides when an overload frame must be started. On every sample strobe it looks at three things: the sampled bus level, the field the controller is currently in, and the bit index within that field. When a dominant level shows up at one of the few positions where the protocol calls for an overload frame, the block raises a single-cycle start request. The frame state machine then sends the overload flag and delimiter. That sequencer is not part of this block.

Four field codes are watched: interframe space (intermission), end of frame, error delimiter and overload delimiter. The end-of-frame condition applies only while the controller is the receiver of the current frame. Every position limit is a parameter, so the same block can be reused with a different field numbering.

Top module: `can_ovld_detect`

## Requirements
- R1: A strobed dominant sample (`smp_bit`=0) with `fld_sel`=0 (intermission) and `bit_idx`=0 gives `ovld_start`=1 in the cycle after the strobe edge. Bit indices count from 0.
- R2: The same applies to intermission bit index 1.
- R3: A strobed dominant sample with `fld_sel`=1 (end of frame) and `bit_idx`=6 (the last bit) gives a request when `rx_mode`=1.
- R4: The end-of-frame condition of R3 gives no request when `rx_mode`=0.
- R5: A strobed dominant sample with `fld_sel`=2 (error delimiter) and `bit_idx`=7 gives a request, whatever the value of `rx_mode`.
- R6: A strobed dominant sample with `fld_sel`=3 (overload delimiter) and `bit_idx`=7 gives a request, whatever the value of `rx_mode`.
- R7: A dominant sample at intermission bit index 2 gives no request.
- R8: A recessive sample (`smp_bit`=1) never gives a request.
- R9: With `smp_stb`=0 no request is given, so each strobe gives at most one single-cycle pulse.
- R10: Synchronous reset (`rst`=1) forces `ovld_start` to 0 at the next edge, even when a triggering sample is strobed.
- R11: No other combination of field and bit index gives a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_stb | input | 1 | One-cycle strobe marking a valid bus sample |
| smp_bit | input | 1 | Sampled bus level, 0 = dominant |
| fld_sel | input | 2 | Current field: 0 intermission, 1 end of frame, 2 error delimiter, 3 overload delimiter |
| bit_idx | input | IDX_W | Bit index within the field, counting from 0 |
| rx_mode | input | 1 | 1 while the current frame is being received |
| ovld_start | output | 1 | Registered one-cycle overload start request |

## Verification
The assertions assume that the field, index, receive flag and sampled bit are stable and meaningful on any cycle where the strobe is high. They check only the value of the request on the cycle after that strobe. The bench drives each input vector for exactly one cycle, on the falling clock edge. It sweeps every combination of field, index, bus level, receive flag and strobe, so every input it presents is a legal sample. It also places a reset cycle over a triggering sample.

// File: rtl/ovld_pkg.sv
package ovld_pkg;
  typedef enum logic [1:0] {
    FLD_IFS    = 2'd0,
    FLD_EOF    = 2'd1,
    FLD_ERRDLM = 2'd2,
    FLD_OVLDLM = 2'd3
  } fld_e;
endpackage

// File: rtl/ovld_slot_decode.sv
// Combinational decode of the bit positions where a dominant sample
// calls for an overload frame.
module ovld_slot_decode #(
  parameter int IDX_W      = 3,
  parameter int IFS_CHECK  = 2,
  parameter int EOF_LAST   = 6,
  parameter int DELIM_LAST = 7
) (
  input  ovld_pkg::fld_e   fld,
  input  logic [IDX_W-1:0] idx,
  input  logic             rx_mode,
  output logic             slot_hit
);
  import ovld_pkg::*;

  logic [IFS_CHECK-1:0] ifs_pos;
  logic ifs_any, eof_hit, dlm_hit;

  // one comparator for each sensitive intermission bit
  for (genvar g = 0; g < IFS_CHECK; g++) begin : g_ifs
    assign ifs_pos[g] = (idx == IDX_W'(g));
  end

  assign ifs_any = |ifs_pos;
  assign eof_hit = (idx == IDX_W'(EOF_LAST)) && rx_mode;
  assign dlm_hit = (idx == IDX_W'(DELIM_LAST));

  always_comb begin
    unique case (fld)
      FLD_IFS:    slot_hit = ifs_any;
      FLD_EOF:    slot_hit = eof_hit;
      FLD_ERRDLM: slot_hit = dlm_hit;
      FLD_OVLDLM: slot_hit = dlm_hit;
      default:    slot_hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/ovld_req_reg.sv
// Qualifies the decoded slot with the strobe and a dominant level, then registers the result.
module ovld_req_reg (
  input  logic clk,
  input  logic rst,
  input  logic stb,
  input  logic bus_lvl,
  input  logic slot_hit,
  output logic req
);
  always_ff @(posedge clk) begin
    if (rst) req <= 1'b0;
    else     req <= stb & ~bus_lvl & slot_hit;
  end
endmodule

// File: rtl/can_ovld_detect.sv
module can_ovld_detect #(
  parameter int IDX_W      = 3,
  parameter int IFS_CHECK  = 2,
  parameter int EOF_LAST   = 6,
  parameter int DELIM_LAST = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             smp_stb,
  input  logic             smp_bit,
  input  logic [1:0]       fld_sel,
  input  logic [IDX_W-1:0] bit_idx,
  input  logic             rx_mode,
  output logic             ovld_start
);
  import ovld_pkg::*;

  fld_e fld;
  logic hit;

  assign fld = fld_e'(fld_sel);

  ovld_slot_decode #(
    .IDX_W(IDX_W), .IFS_CHECK(IFS_CHECK),
    .EOF_LAST(EOF_LAST), .DELIM_LAST(DELIM_LAST)
  ) u_dec (
    .fld(fld), .idx(bit_idx), .rx_mode(rx_mode), .slot_hit(hit)
  );

  ovld_req_reg u_req (
    .clk(clk), .rst(rst), .stb(smp_stb), .bus_lvl(smp_bit),
    .slot_hit(hit), .req(ovld_start)
  );
endmodule

// File: rtl/ovld_chk.sv
module ovld_chk #(
  parameter int IDX_W = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             smp_stb,
  input logic             smp_bit,
  input logic [1:0]       fld_sel,
  input logic [IDX_W-1:0] bit_idx,
  input logic             rx_mode,
  input logic             ovld_start
);
  logic rst_d = 1'b0;
  always_ff @(posedge clk) begin
    rst_d <= rst;
    if (rst_d) a_r10_reset_clears: assert (!ovld_start);
  end

  a_r1_ifs_first: assert property (@(posedge clk) disable iff (rst)
    (smp_stb && !smp_bit && fld_sel == 2'd0 && bit_idx == IDX_W'(0)) |=> ovld_start);

  a_r2_ifs_second: assert property (@(posedge clk) disable iff (rst)
    (smp_stb && !smp_bit && fld_sel == 2'd0 && bit_idx == IDX_W'(1)) |=> ovld_start);

  a_r3_eof_rx: assert property (@(posedge clk) disable iff (rst)
    (smp_stb && !smp_bit && fld_sel == 2'd1 && bit_idx == IDX_W'(6) && rx_mode) |=> ovld_start);

  a_r4_eof_tx: assert property (@(posedge clk) disable iff (rst)
    (smp_stb && fld_sel == 2'd1 && !rx_mode) |=> !ovld_start);

  a_r5_r6_delim: assert property (@(posedge clk) disable iff (rst)
    (smp_stb && !smp_bit && fld_sel[1] && bit_idx == IDX_W'(7)) |=> ovld_start);

  a_r7_ifs_third: assert property (@(posedge clk) disable iff (rst)
    (smp_stb && fld_sel == 2'd0 && bit_idx == IDX_W'(2)) |=> !ovld_start);

  a_r8_recessive: assert property (@(posedge clk) disable iff (rst)
    (smp_stb && smp_bit) |=> !ovld_start);

  a_r9_no_strobe: assert property (@(posedge clk) disable iff (rst)
    !smp_stb |=> !ovld_start);
endmodule

bind can_ovld_detect ovld_chk #(.IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst(rst), .smp_stb(smp_stb), .smp_bit(smp_bit),
  .fld_sel(fld_sel), .bit_idx(bit_idx), .rx_mode(rx_mode),
  .ovld_start(ovld_start)
);

// File: tb/sim_can_ovld_detect.sv
`timescale 1ns/1ps
module sim_can_ovld_detect;
  localparam int IDX_W = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic smp_stb = 1'b0, smp_bit = 1'b1, rx_mode = 1'b0;
  logic [1:0] fld_sel = 2'd0;
  logic [IDX_W-1:0] bit_idx = '0;
  logic ovld_start;
  int total = 0, bad = 0;

  always #4 clk = ~clk;   // 125 MHz

  can_ovld_detect #(.IDX_W(IDX_W)) u0 (
    .clk(clk), .rst(rst), .smp_stb(smp_stb), .smp_bit(smp_bit),
    .fld_sel(fld_sel), .bit_idx(bit_idx), .rx_mode(rx_mode),
    .ovld_start(ovld_start)
  );

  function automatic logic want(int f, int i, int b, int r, int s);
    if (s == 0 || b == 1) return 1'b0;
    if (f == 0) return (i < 2);
    if (f == 1) return (i == 6) && (r == 1);
    return (i == 7);
  endfunction

  function automatic string tag(int f, int i, int b, int r, int s);
    if (s == 0) return "R9";
    if (b == 1) return "R8";
    if (f == 0 && i == 0) return "R1";
    if (f == 0 && i == 1) return "R2";
    if (f == 0 && i == 2) return "R7";
    if (f == 1 && i == 6) return (r == 1) ? "R3" : "R4";
    if (f == 2 && i == 7) return "R5";
    if (f == 3 && i == 7) return "R6";
    return "R11";
  endfunction

  task automatic check(string req, logic got, logic exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: ovld_start=%b expected %b", req, got, exp);
    end
  endtask

  initial begin
    #200000;
    bad++;
    $display("FAIL watchdog: run hung, got=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R10", ovld_start, 1'b0);          // reset state
    rst = 1'b0;
    @(negedge clk);
    check("R9", ovld_start, 1'b0);
    // exhaustive sweep: one vector per cycle, checked one cycle later
    for (int s = 0; s < 2; s++)
      for (int f = 0; f < 4; f++)
        for (int i = 0; i < 8; i++)
          for (int b = 0; b < 2; b++)
            for (int r = 0; r < 2; r++) begin
              smp_stb = s[0]; fld_sel = f[1:0]; bit_idx = i[IDX_W-1:0];
              smp_bit = b[0]; rx_mode = r[0];
              @(negedge clk);
              check(tag(f, i, b, r, s), ovld_start, want(f, i, b, r, s));
            end
    // strobe held for one cycle only: the pulse lasts one cycle (R9)
    smp_stb = 1'b1; fld_sel = 2'd3; bit_idx = 3'd7; smp_bit = 1'b0;
    @(negedge clk);
    check("R6", ovld_start, 1'b1);
    smp_stb = 1'b0;
    @(negedge clk);
    check("R9", ovld_start, 1'b0);
    // reset overrides a triggering sample (R10)
    smp_stb = 1'b1; fld_sel = 2'd0; bit_idx = 3'd0; smp_bit = 1'b0; rst = 1'b1;
    @(negedge clk);
    check("R10", ovld_start, 1'b0);
    rst = 1'b0;
    @(negedge clk);
    check("R1", ovld_start, 1'b1);
    smp_stb = 1'b0;
    @(negedge clk);
    check("R9", ovld_start, 1'b0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule